// File: doc/BRIEF.md
# Serial Register Interface Slave

This block is the slave side of a synchronous serial control port. It gives a host processor read and write access to a bank of 32 byte-wide configuration registers. A host frames each transfer with an active-low chip-select. Inside the frame it sends one instruction byte, then one to four data bytes, all clocked by a host-driven serial clock. The instruction carries a read/write flag, a byte count and a start address. An internal address counter steps the address after every data byte of a burst. The whole register bank is also presented as a flat vector to the logic the registers configure.

Register 0 configures the port itself. It holds the bit order (MSB-first or LSB-first) and the read-data pin selection: the shared bidirectional data pin, or a separate data output. It also holds a self-clearing software-reset bit that returns every other register to its default. A change to register 0 applies from the bit that completes it, so any later bytes of the same burst use the new settings. A control byte that reads the same in both bit orders lets a host regain control of a port whose configuration it has lost.

The serial clock, chip-select and data input are synchronised into the system clock. The serial clock must therefore run well below the system clock rate.

Top module: `sri_slave`

## Requirements
- R1: After reset, register 0 reads 0x00, and every register n from 1 to 31 holds ((29·n) mod 256) XOR 0xA5. The data-pin output enable, the bidirectional data output and the separate data output are all low.
- R2: The instruction byte is the first byte after chip-select falls. Its bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold a count N, and the transfer then carries N+1 data bytes. Bits 4:0 hold the start address.
- R3: Each completed write data byte is stored in the addressed register and appears on the matching byte lane (lane n is bits 8n+7..8n) of the register bank output.
- R4: When register 0 bit 6 is 0, bytes are shifted most significant bit first. The address decrements after every data byte and wraps from 0 to 31.
- R5: When register 0 bit 6 is 1, the instruction and data bytes are shifted least significant bit first. The address increments after every data byte and wraps from 31 to 0.
- R6: Once the N+1 data bytes are done, further serial clocks are ignored until chip-select rises. No register changes.
- R7: Chip-select rising at any point ends the transfer. A partly shifted byte is discarded, and the next frame starts again with an instruction byte.
- R8: With register 0 bit 7 at 0, read data is driven on the bidirectional data output and changes after falling serial-clock edges, so the host samples it on rising edges. The output enable is high only during the data bytes of a read.
- R9: With register 0 bit 7 at 1, read data is driven on the separate data output. The output enable and the bidirectional data output stay low.
- R10: A write to register 0 takes effect from its last bit. The address step after that byte, and the bit order of the following bytes in the same burst, follow the newly written value.
- R11: Writing register 0 with bit 5 set returns registers 1 to 31 to their R1 defaults. Register 0 takes the written value with bit 5 cleared, and the burst carries on.
- R12: A register-0 write of the form XY1001YX in binary, sent with write instruction 0x00, gives the same result whichever bit order the host uses. For example, 0x66 leaves register 0 at 0x46 with the other registers at their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Active-low chip-select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_sdio_i | input | 1 | Serial data in (bidirectional pin, input side) |
| spi_sdio_o | output | 1 | Serial read data on the bidirectional pin |
| spi_sdio_oe | output | 1 | Output enable for the bidirectional pin |
| spi_sdo | output | 1 | Serial read data on the separate output pin |
| cfg_bank | output | 256 | All 32 registers, register n on bits 8n+7..8n |

## Verification
A bit counter out of step with the frame shows up at the first committed byte. The instruction then decodes to the wrong address or count, so a wrong lane changes on the bank output within one byte time of the fault. A wrong address step shows up as early as the second data byte of a burst. Wrong bit-order state appears as a reversed byte in the bank or in read data during the same transfer. Output-enable or pin-selection faults are visible at the first data bit of a read, half a serial clock after the instruction byte ends.

// File: rtl/sri_pkg.sv
// Shared constants, types and default values for the serial register slave.
// Assumes byte-wide registers; the config bit positions refer to register 0.
package sri_pkg;

    localparam int unsigned SRI_NREG = 32;
    localparam int unsigned SRI_AW   = 5;
    localparam int unsigned SRI_DW   = 8;

    localparam int unsigned CFG_BIT_4WIRE = 7;
    localparam int unsigned CFG_BIT_LSB   = 6;
    localparam int unsigned CFG_BIT_SRST  = 5;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } sri_phase_e;

    // Default value of register idx: 0 for the port register, a spread pattern otherwise
    function automatic logic [7:0] sri_reg_default(input int unsigned idx);
        logic [7:0] v;
        v = 8'(idx * 29) ^ 8'hA5;
        return (idx == 0) ? 8'h00 : v;
    endfunction

endpackage

// File: rtl/sri_sync.sv
// Brings the host serial signals into the system clock domain and detects
// serial clock edges. Assumes the serial clock is much slower than clk.
// All three inputs see the same number of stages so data stays aligned.
module sri_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic csn_o,
    output logic sdi_o,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic [STAGES-1:0] csn_q;
    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] sdi_q;
    logic              sclk_d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop of each chain captures the pin
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    csn_q[0]  <= 1'b1;
                    sclk_q[0] <= 1'b0;
                    sdi_q[0]  <= 1'b0;
                end else begin
                    csn_q[0]  <= csn_i;
                    sclk_q[0] <= sclk_i;
                    sdi_q[0]  <= sdi_i;
                end
            end
        end else begin : g_next
            // Later flops copy the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    csn_q[g]  <= 1'b1;
                    sclk_q[g] <= 1'b0;
                    sdi_q[g]  <= 1'b0;
                end else begin
                    csn_q[g]  <= csn_q[g-1];
                    sclk_q[g] <= sclk_q[g-1];
                    sdi_q[g]  <= sdi_q[g-1];
                end
            end
        end
    end

    // Delayed copy of the synchronised serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_q[STAGES-1];
    end

    assign csn_o     = csn_q[STAGES-1];
    assign sdi_o     = sdi_q[STAGES-1];
    assign sclk_rise = sclk_q[STAGES-1] & ~sclk_d;
    assign sclk_fall = ~sclk_q[STAGES-1] & sclk_d;

endmodule

// File: rtl/sri_frame.sv
// Frame engine: shifts bits in on rising serial clock edges, decodes the
// instruction byte, sequences the burst address and drives read data on
// falling edges. Assumes synchronised inputs and single-cycle edge strobes.
// Bit order and address direction come from register 0 at the moment of use.
module sri_frame
    import sri_pkg::*;
#(
    parameter int unsigned AW = SRI_AW,
    parameter int unsigned DW = SRI_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csn,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdi,
    input  logic          lsb_first,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [AW-1:0] rd_addr,
    output logic          sdo,
    output logic          rd_active
);

    localparam int unsigned CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    sri_phase_e    phase;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] rd_byte;
    logic [AW-1:0] addr;
    logic [1:0]    bytes_left;
    logic          is_read;

    logic [DW-1:0] shifted;
    logic          byte_done;
    logic          step_up;
    logic [AW-1:0] addr_next;

    // Next shift value, byte completion and address sequencing
    always_comb begin
        shifted   = lsb_first ? {sdi, shreg[DW-1:1]} : {shreg[DW-2:0], sdi};
        byte_done = rise && !csn && (phase != PH_DONE) && (bit_cnt == LAST);
        wr_en     = byte_done && (phase == PH_DATA) && !is_read;
        step_up   = (wr_en && (addr == '0)) ? shifted[CFG_BIT_LSB] : lsb_first;
        addr_next = step_up ? addr + AW'(1) : addr - AW'(1);
        rd_addr   = (phase == PH_INSTR) ? shifted[AW-1:0] : addr_next;
    end

    assign wr_addr   = addr;
    assign wr_data   = shifted;
    assign rd_active = (phase == PH_DATA) && is_read;

    // Frame sequencing: shift, decode, step address and drive read bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_INSTR;
            bit_cnt    <= '0;
            shreg      <= '0;
            rd_byte    <= '0;
            addr       <= '0;
            bytes_left <= '0;
            is_read    <= 1'b0;
            sdo        <= 1'b0;
        end else if (csn) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            sdo     <= 1'b0;
        end else begin
            if (rise && (phase != PH_DONE)) begin
                shreg   <= shifted;
                bit_cnt <= bit_cnt + CW'(1);
                if (bit_cnt == LAST) begin
                    rd_byte <= rd_data;
                    if (phase == PH_INSTR) begin
                        is_read    <= shifted[DW-1];
                        bytes_left <= shifted[DW-2:DW-3];
                        addr       <= shifted[AW-1:0];
                        phase      <= PH_DATA;
                    end else begin
                        addr <= addr_next;
                        if (bytes_left == 2'd0) phase <= PH_DONE;
                        else                    bytes_left <= bytes_left - 2'd1;
                    end
                end
            end
            if (fall && (phase == PH_DATA) && is_read) begin
                sdo <= lsb_first ? rd_byte[bit_cnt] : rd_byte[LAST - bit_cnt];
            end
        end
    end

endmodule

// File: rtl/sri_regbank.sv
// Register file of byte-wide configuration registers. Register 0 holds the
// port configuration and a self-clearing software reset that restores all
// other registers. Assumes at most one write per cycle from the frame engine.
module sri_regbank
    import sri_pkg::*;
#(
    parameter int unsigned NREG = SRI_NREG,
    parameter int unsigned AW   = SRI_AW,
    parameter int unsigned DW   = SRI_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              cfg_lsb,
    output logic              cfg_4wire,
    output logic [NREG*DW-1:0] bank_flat
);

    localparam logic [DW-1:0] SRST_MASK = ~(DW'(1) << CFG_BIT_SRST);

    logic soft_rst;

    assign soft_rst = wr_en && (wr_addr == '0) && wr_data[CFG_BIT_SRST];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] q;
        if (g == 0) begin : g_port
            // Port configuration register, reset bit never stored
            always_ff @(posedge clk) begin
                if (!rst_n)                         q <= DW'(sri_reg_default(0));
                else if (wr_en && (wr_addr == '0))  q <= wr_data & SRST_MASK;
            end
        end else begin : g_cfg
            // Ordinary register, restored by hardware or software reset
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst)                   q <= DW'(sri_reg_default(g));
                else if (wr_en && (wr_addr == AW'(g)))    q <= wr_data;
            end
        end
        assign bank_flat[g*DW +: DW] = q;
    end

    assign rd_data   = bank_flat[rd_addr*DW +: DW];
    assign cfg_lsb   = bank_flat[CFG_BIT_LSB];
    assign cfg_4wire = bank_flat[CFG_BIT_4WIRE];

endmodule

// File: rtl/sri_slave.sv
// Top of the serial register slave: synchroniser, frame engine and register
// bank. Assumes the host serial clock idles low and is far slower than clk.
// Read data goes to the bidirectional pin or the separate pin per register 0.
module sri_slave
    import sri_pkg::*;
#(
    parameter int unsigned NREG        = SRI_NREG,
    parameter int unsigned AW          = SRI_AW,
    parameter int unsigned DW          = SRI_DW,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_csn,
    input  logic               spi_sclk,
    input  logic               spi_sdio_i,
    output logic               spi_sdio_o,
    output logic               spi_sdio_oe,
    output logic               spi_sdo,
    output logic [NREG*DW-1:0] cfg_bank
);

    logic          csn_s;
    logic          sdi_s;
    logic          rise;
    logic          fall;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          cfg_lsb;
    logic          cfg_4wire;
    logic          sdo_q;
    logic          rd_active;

    sri_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_i     (spi_csn),
        .sclk_i    (spi_sclk),
        .sdi_i     (spi_sdio_i),
        .csn_o     (csn_s),
        .sdi_o     (sdi_s),
        .sclk_rise (rise),
        .sclk_fall (fall)
    );

    sri_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn       (csn_s),
        .rise      (rise),
        .fall      (fall),
        .sdi       (sdi_s),
        .lsb_first (cfg_lsb),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .sdo       (sdo_q),
        .rd_active (rd_active)
    );

    sri_regbank #(.NREG(NREG), .AW(AW), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg_lsb   (cfg_lsb),
        .cfg_4wire (cfg_4wire),
        .bank_flat (cfg_bank)
    );

    assign spi_sdio_o  = cfg_4wire ? 1'b0 : sdo_q;
    assign spi_sdo     = cfg_4wire ? sdo_q : 1'b0;
    assign spi_sdio_oe = !cfg_4wire && rd_active && !csn_s;

endmodule

// File: rtl/sri_checker.sv
// Protocol checker for sri_slave, attached by bind. Observes ports and the
// write strobe between frame engine and register bank.
module sri_checker
    import sri_pkg::*;
#(
    parameter int unsigned NREG = SRI_NREG,
    parameter int unsigned AW   = SRI_AW,
    parameter int unsigned DW   = SRI_DW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               spi_csn,
    input logic               spi_sdio_oe,
    input logic [NREG*DW-1:0] cfg_bank,
    input logic               wr_en,
    input logic [AW-1:0]      wr_addr,
    input logic [DW-1:0]      wr_data
);

    function automatic logic [NREG*DW-1:0] build_defaults();
        logic [NREG*DW-1:0] v;
        v = '0;
        for (int i = 0; i < int'(NREG); i++) v[i*DW +: DW] = DW'(sri_reg_default(i));
        return v;
    endfunction

    localparam logic [NREG*DW-1:0] DEFAULTS = build_defaults();
    localparam logic [DW-1:0] SRST_MASK = ~(DW'(1) << CFG_BIT_SRST);

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_bank == DEFAULTS)); // R1

    AST_WRITE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != '0)) |=> (DW'(cfg_bank >> ($past(wr_addr) * DW)) == $past(wr_data))); // R3

    AST_SRST_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0) && wr_data[CFG_BIT_SRST])
        |=> (cfg_bank[NREG*DW-1:DW] == DEFAULTS[NREG*DW-1:DW])); // R11

    AST_PORT_REG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == '0)) |=> (cfg_bank[DW-1:0] == ($past(wr_data) & SRST_MASK))); // R11

    AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2)) |-> !spi_sdio_oe); // R8

    AST_IDLE_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
        |=> $stable(cfg_bank)); // R7

    AST_OE_3WIRE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdio_oe |-> !cfg_bank[CFG_BIT_4WIRE]); // R9

endmodule

bind sri_slave sri_checker #(.NREG(NREG), .AW(AW), .DW(DW)) u_sri_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_csn     (spi_csn),
    .spi_sdio_oe (spi_sdio_oe),
    .cfg_bank    (cfg_bank),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
);

// File: tb/test_sri_slave.sv
// Self-checking bench: vector table of transfers, then directed tests.
module test_sri_slave;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic         csn;
    logic         sclk;
    logic         sdi;
    wire          sdio_o;
    wire          sdio_oe;
    wire          sdo;
    wire  [255:0] bank;

    sri_slave i_sri_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn     (csn),
        .spi_sclk    (sclk),
        .spi_sdio_i  (sdi),
        .spi_sdio_o  (sdio_o),
        .spi_sdio_oe (sdio_oe),
        .spi_sdo     (sdo),
        .cfg_bank    (bank)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    int   oe_hi;
    int   sdio_hi;
    logic [7:0] mreg [32];

    // {read, count, address, data bytes (first byte lowest)}
    localparam logic [39:0] VEC [8] = '{
        {1'b0, 2'd0, 5'h05, 32'h0000003C},
        {1'b1, 2'd0, 5'h05, 32'h00000000},
        {1'b0, 2'd3, 5'h10, 32'h44332211},
        {1'b1, 2'd3, 5'h10, 32'h00000000},
        {1'b1, 2'd2, 5'h00, 32'h00000000},
        {1'b0, 2'd1, 5'h1F, 32'h0000B2A1},
        {1'b1, 2'd1, 5'h1F, 32'h00000000},
        {1'b1, 2'd1, 5'h08, 32'h00000000}
    };

    function automatic logic [7:0] exp_default(input int i);
        return (i == 0) ? 8'h00 : (8'(i * 29) ^ 8'hA5);
    endfunction

    function automatic logic [255:0] model_flat();
        logic [255:0] v;
        for (int i = 0; i < 32; i++) v[i*8 +: 8] = mreg[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        check(bank === model_flat(), req, "register bank", bank, model_flat());
    endtask

    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        if (a == 5'd0) begin
            if (d[5]) for (int i = 1; i < 32; i++) mreg[i] = exp_default(i);
            mreg[0] = d & 8'hDF;
        end else begin
            mreg[a] = d;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic got);
        sdi = b;
        wait_clk(6);
        got = mreg[0][7] ? sdo : sdio_o;
        if (sdio_oe) oe_hi++;
        if (sdio_o) sdio_hi++;
        sclk = 1'b1;
        wait_clk(6);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit lsb, output logic [7:0] got);
        logic b;
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            send_bit(v[idx], b);
            got[idx] = b;
        end
    endtask

    // One framed transfer; order < 0 follows the model's bit order
    task automatic do_xfer(input bit rd, input logic [1:0] n, input logic [4:0] a0,
                           input logic [31:0] data, input int order, input int extra,
                           input string req);
        logic [7:0] cap;
        logic [4:0] a;
        bit lsb;
        a = a0;
        oe_hi = 0;
        sdio_hi = 0;
        lsb = (order < 0) ? mreg[0][6] : order[0];
        csn = 1'b0;
        wait_clk(6);
        send_byte({rd, n, a0}, lsb, cap);
        for (int k = 0; k <= int'(n); k++) begin
            lsb = (order < 0) ? mreg[0][6] : order[0];
            send_byte(data[k*8 +: 8], lsb, cap);
            if (rd) check(cap === mreg[a], req, $sformatf("read addr %0d", a), cap, mreg[a]);
            else    model_write(a, data[k*8 +: 8]);
            a = mreg[0][6] ? a + 5'd1 : a - 5'd1;
        end
        for (int e = 0; e < extra; e++) send_byte(8'h99, lsb, cap);
        wait_clk(6);
        csn = 1'b1;
        wait_clk(8);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] cap;
        rst_n = 1'b0;
        csn   = 1'b1;
        sclk  = 1'b0;
        sdi   = 1'b0;
        for (int i = 0; i < 32; i++) mreg[i] = exp_default(i);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        check_bank("R1");
        check(sdio_oe === 1'b0, "R1", "output enable", sdio_oe, 1'b0);
        check(sdio_o === 1'b0, "R1", "sdio out", sdio_o, 1'b0);
        check(sdo === 1'b0, "R1", "sdo out", sdo, 1'b0);

        // Vector table: MSB-first reads and writes, single and burst (R2 R3 R4 R8)
        for (int v = 0; v < 8; v++) begin
            bit rd;
            logic [1:0] n;
            string tag;
            rd  = VEC[v][39];
            n   = VEC[v][38:37];
            tag = (n != 2'd0) ? "R4" : (rd ? "R8" : "R2");
            do_xfer(rd, n, VEC[v][36:32], VEC[v][31:0], -1, 0, tag);
            check_bank("R3");
            if (rd) check(oe_hi == 8 * (int'(n) + 1), "R8", "oe bit count", oe_hi, 8 * (int'(n) + 1));
            else    check(oe_hi == 0, "R8", "oe during write", oe_hi, 0);
            check(sdio_oe === 1'b0, "R8", "oe after frame", sdio_oe, 1'b0);
        end

        // R6: clocks after the counted bytes are ignored
        do_xfer(1'b0, 2'd0, 5'h06, 32'h00000077, -1, 2, "R6");
        check_bank("R6");

        // R7: aborted byte is dropped, next frame realigns
        csn = 1'b0;
        wait_clk(6);
        send_byte({1'b0, 2'd0, 5'h08}, 1'b0, cap);
        for (int i = 0; i < 5; i++) begin
            logic b;
            send_bit(1'b1, b);
        end
        wait_clk(6);
        csn = 1'b1;
        wait_clk(8);
        check_bank("R7");
        do_xfer(1'b0, 2'd0, 5'h08, 32'h00000042, -1, 0, "R7");
        check_bank("R7");

        // R9: separate data output selected
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000080, -1, 0, "R9");
        do_xfer(1'b1, 2'd0, 5'h05, 32'h0, -1, 0, "R9");
        check(oe_hi == 0, "R9", "oe in 4-wire read", oe_hi, 0);
        check(sdio_hi == 0, "R9", "sdio activity in 4-wire read", sdio_hi, 0);
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000000, -1, 0, "R9");
        check_bank("R9");

        // R5: LSB-first, incrementing address wrapping 31 to 0
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000040, -1, 0, "R5");
        do_xfer(1'b0, 2'd1, 5'h1F, 32'h000040C5, -1, 0, "R5");
        check_bank("R5");
        do_xfer(1'b1, 2'd1, 5'h1F, 32'h0, -1, 0, "R5");

        // R10: order switch mid-burst changes step and later bytes
        do_xfer(1'b0, 2'd2, 5'h00, 32'h009E6D00, -1, 0, "R10");
        check_bank("R10");
        check(bank[7:0] === 8'h00, "R10", "port register", bank[7:0], 8'h00);

        // R11: software reset inside a burst
        do_xfer(1'b0, 2'd1, 5'h00, 32'h00001220, -1, 0, "R11");
        check_bank("R11");

        // R12: symmetric recovery byte in either host order
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000040, -1, 0, "R12");
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000066, 0, 0, "R12");
        check_bank("R12");
        do_xfer(1'b0, 2'd0, 5'h00, 32'h00000066, 1, 0, "R12");
        check_bank("R12");
        do_xfer(1'b1, 2'd0, 5'h00, 32'h0, -1, 0, "R12");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule